// File: doc/BRIEF.md
# Timer-Driven Pulse Compare Channel

This block turns a count value into a shaped digital pulse. Two free-running up-counters act as time bases. Each counter has its own period register and its own run bit. The channel compares the count of the time base it has selected against two values. The first value is the count at which the output goes high. The second is the count at which it goes low again. Every trailing edge raises a sticky event flag. When enabled, that flag becomes an interrupt request.

Software configures the channel through a small write-only register port. It loads the two edge counts and the periods, and then writes the control word. Writing a pulse mode into the control word arms the channel and forces the output low. Once the selected timer is started, the channel produces either one pulse or a pulse on every timer period. In one-shot mode the channel stays quiet after its single pulse. A new pulse needs another control write; the channel does not have to be disabled first.

Top module: `ocp_pulse_gen`

## Requirements
- R1: After reset the pulse output, the event flag and the interrupt request are low, both counters hold zero and are stopped, and all registers are zero.
- R2: Register map on `wr_addr`:
  - 0: control. Bits [2:0] select the mode, bit 3 selects the time base (0 = timer 0, 1 = timer 1), bit 4 enables the interrupt.
  - 1: rising-edge count.
  - 2: falling-edge count.
  - 3: period of timer 0.
  - 4: period of timer 1.
  - 5: timer control. Bits [1:0] are the run bits of timers 0 and 1; a 1 in bits [3:2] clears the count of timer 0 or 1.
  - 6: flag clear (bit 0).

  Mode 3'b100 is one-shot and 3'b101 is continuous. Any other mode keeps the output low.
- R3: A write to the control register drives the output low on the next cycle and re-arms the channel, whatever state it was in before.
- R4: When the selected counter is running and equals the rising-edge count, the output goes high one cycle later.
- R5: While the output is high, when the running selected counter equals the falling-edge count, the output goes low one cycle later.
- R6: In one-shot mode only one pulse is produced, even while the timer keeps wrapping. Another control write with mode 3'b100 arms exactly one further pulse.
- R7: In continuous mode a pulse starts on every timer period, so rising edges are period+1 cycles apart.
- R8: A running counter counts up from zero by one each cycle. When it equals its period register it returns to zero on the next cycle.
- R9: The time-base select bit decides which counter is compared. The other counter has no effect on the output.
- R10: The event flag is set with each trailing edge and stays set until a flag-clear write. The interrupt request is high only while both the flag and the interrupt enable are set.
- R11: If the period is smaller than the falling-edge count, the output stays high after its rising edge and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counting and compares happen on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | DW (16) | Write data |
| pulse_out | output | 1 | Compare pulse output |
| flag_out | output | 1 | Sticky trailing-edge event flag |
| irq_out | output | 1 | Interrupt request (flag and enable) |

## Verification
The hardest case to reach is the one-shot channel that stays silent for many timer wraps. The bench has to show that no second rising edge ever appears, and then that one control write brings back exactly one pulse while the timer keeps running. The stimulus gets there in two ways:
- Each table vector watches a 200-cycle window that spans several periods, counting rising edges and measuring the first pulse's position and width.
- A directed sequence rewrites the control word mid-run, and separately forces the stuck-high state of a period shorter than the falling-edge count, then breaks it with a control write.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
    localparam int AW  = 3;
    localparam int NTB = 2;

    localparam logic [AW-1:0] A_CTRL = 3'd0;
    localparam logic [AW-1:0] A_RISE = 3'd1;
    localparam logic [AW-1:0] A_FALL = 3'd2;
    localparam logic [AW-1:0] A_PER0 = 3'd3;
    localparam logic [AW-1:0] A_TCTL = 3'd5;
    localparam logic [AW-1:0] A_FLAG = 3'd6;

    localparam logic [2:0] M_ONCE = 3'b100;
    localparam logic [2:0] M_LOOP = 3'b101;

    typedef enum logic [1:0] {
        S_ARMED = 2'd0,
        S_HIGH  = 2'd1,
        S_DONE  = 2'd2
    } pstate_e;
endpackage

// File: rtl/ocp_regfile.sv
module ocp_regfile
    import ocp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    output logic [2:0]              mode,
    output logic                    tb_sel,
    output logic                    irq_en,
    output logic [DW-1:0]           rise_val,
    output logic [DW-1:0]           fall_val,
    output logic [NTB-1:0][DW-1:0]  per_val,
    output logic [NTB-1:0]          run,
    output logic [NTB-1:0]          cnt_clr,
    output logic                    arm,
    output logic                    flag_clr
);
    typedef struct packed {
        logic [2:0]             mode;
        logic                   sel;
        logic                   irq_en;
        logic [DW-1:0]          rise;
        logic [DW-1:0]          fall;
        logic [NTB-1:0][DW-1:0] per;
        logic [NTB-1:0]         run;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        arm      = 1'b0;
        flag_clr = 1'b0;
        cnt_clr  = '0;
        if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    r_d.mode   = wr_data[2:0];
                    r_d.sel    = wr_data[3];
                    r_d.irq_en = wr_data[4];
                    arm        = 1'b1;
                end
                A_RISE: r_d.rise = wr_data;
                A_FALL: r_d.fall = wr_data;
                A_TCTL: begin
                    r_d.run = wr_data[NTB-1:0];
                    cnt_clr = wr_data[2*NTB-1:NTB];
                end
                A_FLAG: flag_clr = wr_data[0];
                default: ;
            endcase
            for (int g = 0; g < NTB; g++) begin
                if (wr_addr == A_PER0 + AW'(g)) begin
                    r_d.per[g] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mode     = r_q.mode;
    assign tb_sel   = r_q.sel;
    assign irq_en   = r_q.irq_en;
    assign rise_val = r_q.rise;
    assign fall_val = r_q.fall;
    assign per_val  = r_q.per;
    assign run      = r_q.run;
endmodule

// File: rtl/ocp_timebase.sv
module ocp_timebase #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic [DW-1:0] period,
    output logic [DW-1:0] count
);
    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = (cnt_q == period) ? '0 : cnt_q + DW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/ocp_edge_ctl.sv
module ocp_edge_ctl
    import ocp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] cnt,
    input  logic          tick,
    input  logic [DW-1:0] rise_val,
    input  logic [DW-1:0] fall_val,
    input  logic [2:0]    mode,
    input  logic          arm,
    input  logic          flag_clr,
    input  logic          irq_en,
    output logic          pulse_out,
    output logic          flag_out,
    output logic          irq_out,
    output logic          done
);
    typedef struct packed {
        pstate_e st;
        logic    flag;
    } ctl_t;

    ctl_t c_d, c_q;
    logic hit_rise, hit_fall, active;

    always_comb begin
        hit_rise = tick && (cnt == rise_val);
        hit_fall = tick && (cnt == fall_val);
        active   = (mode == M_ONCE) || (mode == M_LOOP);
        c_d      = c_q;
        if (flag_clr) begin
            c_d.flag = 1'b0;
        end
        if (arm) begin
            c_d.st = S_ARMED;
        end else if (active) begin
            unique case (c_q.st)
                S_ARMED: if (hit_rise) c_d.st = S_HIGH;
                S_HIGH: begin
                    if (hit_fall) begin
                        c_d.st   = (mode == M_LOOP) ? S_ARMED : S_DONE;
                        c_d.flag = 1'b1;
                    end
                end
                S_DONE: ;
                default: c_d.st = S_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{st: S_ARMED, flag: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign pulse_out = (c_q.st == S_HIGH);
    assign flag_out  = c_q.flag;
    assign irq_out   = c_q.flag && irq_en;
    assign done      = (c_q.st == S_DONE);
endmodule

// File: rtl/ocp_pulse_gen.sv
module ocp_pulse_gen
    import ocp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          pulse_out,
    output logic          flag_out,
    output logic          irq_out
);
    logic [2:0]             mode;
    logic                   tb_sel;
    logic                   irq_en;
    logic [DW-1:0]          rise_val;
    logic [DW-1:0]          fall_val;
    logic [NTB-1:0][DW-1:0] per_val;
    logic [NTB-1:0]         run;
    logic [NTB-1:0]         cnt_clr;
    logic [NTB-1:0][DW-1:0] cnt;
    logic                   arm;
    logic                   flag_clr;
    logic [DW-1:0]          sel_cnt;
    logic                   sel_run;
    logic                   done;
    logic [DW-1:0]          cnt_a;
    logic [DW-1:0]          per_a;
    logic                   run_a;
    logic                   clr_a;

    ocp_regfile #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mode     (mode),
        .tb_sel   (tb_sel),
        .irq_en   (irq_en),
        .rise_val (rise_val),
        .fall_val (fall_val),
        .per_val  (per_val),
        .run      (run),
        .cnt_clr  (cnt_clr),
        .arm      (arm),
        .flag_clr (flag_clr)
    );

    for (genvar g = 0; g < NTB; g++) begin : g_tb
        ocp_timebase #(.DW(DW)) u_tb (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run[g]),
            .clr    (cnt_clr[g]),
            .period (per_val[g]),
            .count  (cnt[g])
        );
    end

    assign sel_cnt = cnt[tb_sel];
    assign sel_run = run[tb_sel];

    ocp_edge_ctl #(.DW(DW)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt       (sel_cnt),
        .tick      (sel_run),
        .rise_val  (rise_val),
        .fall_val  (fall_val),
        .mode      (mode),
        .arm       (arm),
        .flag_clr  (flag_clr),
        .irq_en    (irq_en),
        .pulse_out (pulse_out),
        .flag_out  (flag_out),
        .irq_out   (irq_out),
        .done      (done)
    );

    assign cnt_a = cnt[0];
    assign per_a = per_val[0];
    assign run_a = run[0];
    assign clr_a = cnt_clr[0];
endmodule

// File: rtl/ocp_pulse_gen_chk.sv
module ocp_pulse_gen_chk
    import ocp_pkg::*;
#(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          pulse_out,
    input logic          flag_out,
    input logic          irq_out,
    input logic [2:0]    mode,
    input logic [DW-1:0] sel_cnt,
    input logic          sel_run,
    input logic [DW-1:0] fall_val,
    input logic [DW-1:0] cnt_a,
    input logic [DW-1:0] per_a,
    input logic          run_a,
    input logic          clr_a,
    input logic          done
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

    // R3
    arm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !pulse_out);

    // R2
    idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[2:1] != 2'b10) |-> !pulse_out);

    // R5
    fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out && sel_run && (sel_cnt == fall_val) && !ctrl_wr) |=> !pulse_out);

    // R10
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_out) |-> $fell(pulse_out));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> flag_out);

    // R8
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_a && !clr_a && (cnt_a == per_a)) |=> (cnt_a == '0));

    // R6
    once_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ctrl_wr) |=> !pulse_out);
endmodule

bind ocp_pulse_gen ocp_pulse_gen_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pulse_out (pulse_out),
    .flag_out  (flag_out),
    .irq_out   (irq_out),
    .mode      (mode),
    .sel_cnt   (sel_cnt),
    .sel_run   (sel_run),
    .fall_val  (fall_val),
    .cnt_a     (cnt_a),
    .per_a     (per_a),
    .run_a     (run_a),
    .clr_a     (clr_a),
    .done      (done)
);

// File: tb/ocp_pulse_gen_tb.sv
`timescale 1ns/1ps
module ocp_pulse_gen_tb;
    localparam int DW  = 16;
    localparam int WIN = 200;

    typedef struct packed {
        logic [2:0]  mode;
        logic        sel;
        logic [15:0] rise;
        logic [15:0] fall;
        logic [15:0] per;
        logic [15:0] first;
        logic [15:0] width;
        logic [15:0] pulses;
        logic        flag;
    } vec_t;

    // mode, sel, rise, fall, period, first rise cycle, first width, rises in window, flag
    localparam vec_t VECS [5] = '{
        '{3'b100, 1'b0, 16'd5,  16'd12, 16'd20, 16'd6,  16'd7,   16'd1,  1'b1},
        '{3'b101, 1'b0, 16'd3,  16'd8,  16'd15, 16'd4,  16'd5,   16'd13, 1'b1},
        '{3'b101, 1'b1, 16'd0,  16'd4,  16'd9,  16'd1,  16'd4,   16'd20, 1'b1},
        '{3'b100, 1'b1, 16'd10, 16'd30, 16'd40, 16'd11, 16'd20,  16'd1,  1'b1},
        '{3'b101, 1'b0, 16'd6,  16'd50, 16'd20, 16'd7,  16'd194, 16'd1,  1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          pulse_out, flag_out, irq_out;
    int            checks = 0;
    int            errors = 0;

    always #2.5 clk = ~clk;

    ocp_pulse_gen #(.DW(DW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pulse_out (pulse_out),
        .flag_out  (flag_out),
        .irq_out   (irq_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic count_rises(input int n, output int rises);
        logic prev;
        prev  = pulse_out;
        rises = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pulse_out && !prev) rises++;
            prev = pulse_out;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int rises, first, width;
        logic prev, in_first;
        string ftag;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs low after reset
        chk("R1 pulse", int'(pulse_out), 0);
        chk("R1 flag", int'(flag_out), 0);
        chk("R1 irq", int'(irq_out), 0);

        for (int v = 0; v < 5; v++) begin
            wr(3'd5, 16'h000C);
            wr(3'd1, VECS[v].rise);
            wr(3'd2, VECS[v].fall);
            wr(3'd3, VECS[v].sel ? 16'd7 : VECS[v].per);
            wr(3'd4, VECS[v].sel ? VECS[v].per : 16'd7);
            wr(3'd0, {11'd0, 1'b1, VECS[v].sel, VECS[v].mode});
            wr(3'd6, 16'h0001);
            chk("R3 armed low", int'(pulse_out), 0);
            wr(3'd5, 16'h0003);
            prev = pulse_out; rises = 0; first = 0; width = 0; in_first = 1'b0;
            for (int k = 1; k <= WIN; k++) begin
                @(negedge clk);
                if (pulse_out && !prev) begin
                    rises++;
                    if (rises == 1) begin
                        first = k;
                        in_first = 1'b1;
                    end
                end
                if (in_first && !pulse_out) in_first = 1'b0;
                if (in_first) width++;
                prev = pulse_out;
            end
            ftag = (v == 1) ? "R8 first rise" : (VECS[v].sel ? "R9 first rise" : "R4 first rise");
            chk(ftag, first, int'(VECS[v].first));
            chk((v == 4) ? "R11 width" : "R5 width", width, int'(VECS[v].width));
            chk((VECS[v].mode == 3'b100) ? "R6 rises" : "R7 rises", rises, int'(VECS[v].pulses));
            chk("R10 flag", int'(flag_out), int'(VECS[v].flag));
            chk("R10 irq", int'(irq_out), int'(VECS[v].flag));
        end

        // R11 state still high; R3: control write drops it at once
        chk("R11 stuck high", int'(pulse_out), 1);
        wr(3'd0, 16'h0015);
        chk("R3 forced low", int'(pulse_out), 0);

        // R2: non-pulse mode keeps output low while timer matches
        wr(3'd0, 16'h0013);
        count_rises(100, rises);
        chk("R2 idle mode", rises, 0);

        // R6 rearm and R10 interrupt enable off
        wr(3'd5, 16'h000C);
        wr(3'd1, 16'd2);
        wr(3'd2, 16'd5);
        wr(3'd3, 16'd10);
        wr(3'd0, 16'h0004);
        wr(3'd6, 16'h0001);
        wr(3'd5, 16'h0001);
        count_rises(60, rises);
        chk("R6 single", rises, 1);
        chk("R10 flag set", int'(flag_out), 1);
        chk("R10 irq masked", int'(irq_out), 0);
        wr(3'd0, 16'h0004);
        count_rises(30, rises);
        chk("R6 rearm", rises, 1);
        chk("R10 sticky", int'(flag_out), 1);
        wr(3'd6, 16'h0001);
        chk("R10 cleared", int'(flag_out), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule